// File: doc/BRIEF.md
# Predicate Gating Register File

This block keeps a set of one-bit predicate registers and uses them to decide, for every instruction slot issued in a cycle, whether that slot runs or is nullified. Each incoming slot is a 41-bit instruction word with a valid flag. The low six bits of the word name the predicate that qualifies it. The block reads that predicate from the file and raises a per-slot execute-enable only when the slot is valid and the predicate is true. The slot word is passed on unchanged. Its outgoing valid flag is cleared whenever the slot is nullified.

Compare results reach the file through a small number of write ports, and the file takes them at the clock edge. Entry 0 is wired true, so an instruction that names it always runs. This lets unpredicated code and both arms of a branch travel through the same gating path. Only the arm whose predicate holds commits. The other arm is dropped.

Top module: `pred_nullify_unit`

## Requirements
- R1: A synchronous active-high reset sets predicate entries 1 to 63 to false. After reset, a valid slot that names any of those entries has execute-enable low until that entry is written true.
- R2: Entry 0 always reads true. A valid slot whose qualifying index is 0 always has execute-enable high.
- R3: A write to entry 0 is ignored, on either port and with either value. After it, entry 0 still reads true.
- R4: The qualifying-predicate index of a slot is bits [5:0] of its 41-bit word. Bits [40:6] have no effect on gating.
- R5: For each slot i, exec_en[i] = slot_vld_in[i] AND predicate[index of slot i]. Each slot is evaluated independently of the others and independently of its opcode bits.
- R6: slot_out carries each slot word unchanged. slot_vld_out[i] equals exec_en[i], so a slot whose predicate is false leaves with its valid flag cleared.
- R7: A write with its enable high updates the addressed entry at the rising clock edge. Reads in the same cycle return the value held before that write, with no bypass. The new value is seen from the next cycle on.
- R8: There are two write ports, 0 and 1. When both are enabled for the same index, the value on port 1 is stored.
- R9: A slot whose input valid is low has execute-enable low and outgoing valid low, whatever its predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| slot_in | input | 246 | Six 41-bit slot words; slot i occupies bits [41*i+40 : 41*i] |
| slot_vld_in | input | 6 | Valid flag per slot |
| wr_en | input | 2 | Enable per predicate write port |
| wr_idx | input | 12 | Target index per port; port p occupies bits [6*p+5 : 6*p] |
| wr_val | input | 2 | Value written per port |
| slot_out | output | 246 | Slot words passed through |
| slot_vld_out | output | 6 | Valid per slot, cleared on nullification |
| exec_en | output | 6 | Execute-enable per slot |

## Verification
The bench reads a predicate in the same cycle it writes it. A design with a write-to-read bypass would then enable the slot one cycle early. It drives both ports at one index with opposite values, which catches a design that favours port 0. It writes false to entry 0 and then issues slots that name entry 0. A design that stored that write would nullify unpredicated code. Random slots carry random opcode bits and random invalid lanes next to true predicates, so that gating on the wrong bit field, or ignoring the valid flag, shows up as wrong enables.

// File: rtl/pred_gate_pkg.sv
package pred_gate_pkg;

    localparam int SLOT_W    = 41;
    localparam int NUM_PREDS = 64;
    localparam int PIDX_W    = $clog2(NUM_PREDS);
    localparam int NUM_SLOTS = 6;
    localparam int NUM_WR    = 2;

    typedef logic [SLOT_W-1:0] slot_word_t;
    typedef logic [PIDX_W-1:0] pidx_t;

    typedef struct packed {
        logic  en;
        pidx_t idx;
        logic  val;
    } pwrite_t;

    typedef struct packed {
        slot_word_t word;
        logic       vld;
    } slot_t;

    // Qualifying predicate index lives in the low bits of each slot word.
    function automatic pidx_t qual_index(input slot_word_t w);
        return w[PIDX_W-1:0];
    endfunction

endpackage

// File: rtl/pred_store.sv
module pred_store
    import pred_gate_pkg::*;
#(
    parameter int N_PRED = NUM_PREDS,
    parameter int N_WR   = NUM_WR
) (
    input  logic              clk,
    input  logic              rst,
    input  pwrite_t           wr   [N_WR],
    output logic [N_PRED-1:0] pred_vec
);

    logic [N_PRED-1:0] pred_q;
    logic [N_PRED-1:0] pred_d;

    // Ports are applied in ascending order, so a higher port overrides a lower one.
    always_comb begin
        pred_d = pred_q;
        for (int p = 0; p < N_WR; p++) begin
            if (wr[p].en && (wr[p].idx != '0)) begin
                pred_d[wr[p].idx] = wr[p].val;
            end
        end
        pred_d[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= {{(N_PRED-1){1'b0}}, 1'b1};
        end else begin
            pred_q <= pred_d;
        end
    end

    assign pred_vec = pred_q;

    // R8: when both ports target one index, the higher port's value lands
    a_r8_port_priority: assert property (@(posedge clk) disable iff (rst)
        (wr[0].en && wr[N_WR-1].en && (wr[0].idx == wr[N_WR-1].idx) && (wr[0].idx != '0))
        |=> (pred_q[$past(wr[N_WR-1].idx)] == $past(wr[N_WR-1].val)));

    // R7: an unopposed write on port 0 becomes visible on the next cycle
    a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr[0].en && (wr[0].idx != '0) &&
         !(wr[N_WR-1].en && (wr[N_WR-1].idx == wr[0].idx)))
        |=> (pred_q[$past(wr[0].idx)] == $past(wr[0].val)));

endmodule

// File: rtl/pred_slot_gate.sv
module pred_slot_gate
    import pred_gate_pkg::*;
#(
    parameter int N_PRED = NUM_PREDS
) (
    input  slot_t             slot_i,
    input  logic [N_PRED-1:0] pred_vec,
    output slot_t             slot_o,
    output logic              exec_o
);

    pidx_t qp;
    logic  qp_true;

    always_comb begin
        qp      = qual_index(slot_i.word);
        qp_true = pred_vec[qp];
        exec_o  = slot_i.vld & qp_true;
        slot_o.word = slot_i.word;
        slot_o.vld  = exec_o;
    end

endmodule

// File: rtl/pred_nullify_unit.sv
module pred_nullify_unit
    import pred_gate_pkg::*;
#(
    parameter int N_SLOT = NUM_SLOTS,
    parameter int N_WR   = NUM_WR
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SLOT*SLOT_W-1:0] slot_in,
    input  logic [N_SLOT-1:0]        slot_vld_in,
    input  logic [N_WR-1:0]          wr_en,
    input  logic [N_WR*PIDX_W-1:0]   wr_idx,
    input  logic [N_WR-1:0]          wr_val,
    output logic [N_SLOT*SLOT_W-1:0] slot_out,
    output logic [N_SLOT-1:0]        slot_vld_out,
    output logic [N_SLOT-1:0]        exec_en
);

    pwrite_t              wr_port [N_WR];
    logic [NUM_PREDS-1:0] pred_vec;

    for (genvar p = 0; p < N_WR; p++) begin : g_wr
        assign wr_port[p].en  = wr_en[p];
        assign wr_port[p].idx = wr_idx[p*PIDX_W +: PIDX_W];
        assign wr_port[p].val = wr_val[p];
    end

    pred_store #(
        .N_PRED (NUM_PREDS),
        .N_WR   (N_WR)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_port),
        .pred_vec (pred_vec)
    );

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        slot_t in_s;
        slot_t out_s;
        logic  ex_s;

        assign in_s.word = slot_in[s*SLOT_W +: SLOT_W];
        assign in_s.vld  = slot_vld_in[s];

        pred_slot_gate #(
            .N_PRED (NUM_PREDS)
        ) u_gate (
            .slot_i   (in_s),
            .pred_vec (pred_vec),
            .slot_o   (out_s),
            .exec_o   (ex_s)
        );

        assign slot_out[s*SLOT_W +: SLOT_W] = out_s.word;
        assign slot_vld_out[s]              = out_s.vld;
        assign exec_en[s]                   = ex_s;

        // R9: an invalid lane never executes
        a_r9_invalid_idle: assert property (@(posedge clk) disable iff (rst)
            !slot_vld_in[s] |-> (!exec_en[s] && !slot_vld_out[s]));

        // R2: a valid lane naming entry 0 always executes
        a_r2_p0_runs: assert property (@(posedge clk) disable iff (rst)
            (slot_vld_in[s] && (slot_in[s*SLOT_W +: PIDX_W] == '0)) |-> exec_en[s]);
    end

endmodule

// File: tb/test_pred_nullify_unit.sv
module test_pred_nullify_unit;
    import pred_gate_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NS = NUM_SLOTS;
    localparam int NW = NUM_WR;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NS*SLOT_W-1:0] slot_in = '0;
    logic [NS-1:0]        slot_vld_in = '0;
    logic [NW-1:0]        wr_en = '0;
    logic [NW*PIDX_W-1:0] wr_idx = '0;
    logic [NW-1:0]        wr_val = '0;
    logic [NS*SLOT_W-1:0] slot_out;
    logic [NS-1:0]        slot_vld_out;
    logic [NS-1:0]        exec_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic model [NUM_PREDS];

    pred_nullify_unit i_pred_nullify_unit (
        .clk(clk), .rst(rst), .slot_in(slot_in), .slot_vld_in(slot_vld_in),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .slot_out(slot_out), .slot_vld_out(slot_vld_out), .exec_en(exec_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] exp_exec();
        logic [NS-1:0] e;
        for (int s = 0; s < NS; s++) begin
            logic [PIDX_W-1:0] q;
            q = slot_in[s*SLOT_W +: PIDX_W];
            e[s] = slot_vld_in[s] & ((q == 0) ? 1'b1 : model[q]);
        end
        return e;
    endfunction

    task automatic set_slot(int s, logic [SLOT_W-1:0] w, logic v);
        slot_in[s*SLOT_W +: SLOT_W] = w;
        slot_vld_in[s] = v;
    endtask

    task automatic set_wr(int p, logic en, logic [PIDX_W-1:0] idx, logic val);
        wr_en[p] = en;
        wr_idx[p*PIDX_W +: PIDX_W] = idx;
        wr_val[p] = val;
    endtask

    // Check outputs for current inputs, then clock and fold writes into the model.
    task automatic step(string req);
        #1;
        chk(req, "exec_en", 64'(exec_en), 64'(exp_exec()));
        chk("R6", "slot_vld_out", 64'(slot_vld_out), 64'(exp_exec()));
        for (int s = 0; s < NS; s++)
            if (slot_out[s*SLOT_W +: SLOT_W] !== slot_in[s*SLOT_W +: SLOT_W])
                chk("R6", "slot_out", 64'(slot_out[s*SLOT_W +: SLOT_W]),
                    64'(slot_in[s*SLOT_W +: SLOT_W]));
        @(posedge clk);
        for (int p = 0; p < NW; p++)
            if (wr_en[p] && wr_idx[p*PIDX_W +: PIDX_W] != 0)
                model[wr_idx[p*PIDX_W +: PIDX_W]] = wr_val[p];
        @(negedge clk);
    endtask

    function automatic logic [SLOT_W-1:0] rnd_word(logic [PIDX_W-1:0] q);
        logic [SLOT_W-1:0] w;
        w = {$urandom(), $urandom()};
        w[PIDX_W-1:0] = q;
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD*200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NUM_PREDS; i++) model[i] = 1'b0;
        model[0] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: every nonzero entry reads false after reset
        for (int base = 1; base < NUM_PREDS; base += NS) begin
            for (int s = 0; s < NS; s++)
                set_slot(s, rnd_word(PIDX_W'((base + s) % NUM_PREDS)), 1'b1);
            step("R1");
            chk("R1", "exec_en after reset", 64'(exec_en), 64'(((base + NS) > NUM_PREDS) ? 6'b000001 << (NUM_PREDS - base) : 6'b0));
        end

        // R2: entry 0 always true, all lanes
        for (int s = 0; s < NS; s++) set_slot(s, rnd_word(0), 1'b1);
        step("R2");

        // R7: no bypass; write p5 and read it in the same cycle
        for (int s = 0; s < NS; s++) set_slot(s, rnd_word(5), 1'b1);
        set_wr(0, 1'b1, 5, 1'b1);
        #1 chk("R7", "same-cycle read", 64'(exec_en), 64'(0));
        step("R7");
        set_wr(0, 1'b0, 0, 1'b0);
        #1 chk("R7", "next-cycle read", 64'(exec_en), 64'(6'h3f));
        step("R7");

        // R8: both ports same index, port 1 wins (both orderings)
        for (int s = 0; s < NS; s++) set_slot(s, rnd_word(7), 1'b1);
        set_wr(0, 1'b1, 7, 1'b1); set_wr(1, 1'b1, 7, 1'b0);
        step("R8");
        set_wr(0, 1'b0, 0, 1'b0); set_wr(1, 1'b0, 0, 1'b0);
        #1 chk("R8", "port1 wins false", 64'(exec_en), 64'(0));
        set_wr(0, 1'b1, 7, 1'b0); set_wr(1, 1'b1, 7, 1'b1);
        step("R8");
        set_wr(0, 1'b0, 0, 1'b0); set_wr(1, 1'b0, 0, 1'b0);
        #1 chk("R8", "port1 wins true", 64'(exec_en), 64'(6'h3f));
        step("R8");

        // R3: writes of false to entry 0 on both ports are dropped
        set_wr(0, 1'b1, 0, 1'b0); set_wr(1, 1'b1, 0, 1'b0);
        for (int s = 0; s < NS; s++) set_slot(s, rnd_word(0), 1'b1);
        step("R3");
        set_wr(0, 1'b0, 0, 1'b0); set_wr(1, 1'b0, 0, 1'b0);
        #1 chk("R3", "p0 still true", 64'(exec_en), 64'(6'h3f));
        step("R3");

        // R9: invalid lanes with a true predicate stay off
        for (int s = 0; s < NS; s++) set_slot(s, rnd_word((s % 2) ? 5 : 0), 1'b0);
        #1 chk("R9", "invalid lanes", 64'(exec_en), 64'(0));
        step("R9");

        // R4: upper bits equal to a true index do not matter
        for (int s = 0; s < NS; s++) set_slot(s, {35'h5, 6'd9}, 1'b1);
        #1 chk("R4", "index from low bits", 64'(exec_en), 64'(0));
        step("R4");

        // R5: random mix of writes, indices, opcodes and valid flags
        for (int n = 0; n < 3000; n++) begin
            for (int s = 0; s < NS; s++)
                set_slot(s, rnd_word(PIDX_W'($urandom_range(0, 15))), ($urandom_range(0, 3) != 0));
            for (int p = 0; p < NW; p++)
                set_wr(p, $urandom_range(0, 1), PIDX_W'($urandom_range(0, 15)), $urandom_range(0, 1));
            step("R5");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule